// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It divides a fast clock by any integer ratio of the form M×N+A. M is a base modulus picked from two values by a single select bit. N is the main program value and A is the swallow value. A digital dual-modulus prescaler divides the fast clock by M or by M+1. A swallow counter keeps the prescaler at M+1 for the first A prescaler periods of each output cycle. A main counter ends the output cycle after N prescaler periods. Because A of the N periods are one clock longer, the total length is M×N+A input clocks.

The settings `sw_sel`, `swallow_a` and `prog_n` are plain control pins; no data stream crosses the block, so there is no valid/ready handshake and no back-pressure. The block samples all three only at the end of an output cycle. Software may therefore change them at any time, and no output cycle ever gets a length that mixes two settings. Each output cycle produces one pulse on `fp`, one input clock wide. `mod_ctl` shows which modulus the prescaler is using for its current period.

The ratio formula holds only while A is smaller than the effective N. A program value below `N_MIN` is raised to `N_MIN`.

Top module: `pswal_fb_divider`

## Requirements
- R1: While `rst_n` is low, `fp` and `mod_ctl` are both 0.
- R2: With `sw_sel`=0, the base modulus is `PRE_LO`. The distance between two consecutive `fp` pulses is `PRE_LO`×N+A input clocks, for every N from `N_MIN` to 2^`N_W`−1 and every A < N.
- R3: With `sw_sel`=1, the base modulus is `PRE_HI`. The distance between two consecutive `fp` pulses is `PRE_HI`×N+A input clocks, for every legal N and every A < N.
- R4: With A=0, the distance between pulses is exactly M×N, and `mod_ctl` stays 0 for the whole cycle.
- R5: In each output cycle, `mod_ctl` is 1 for exactly A×(M+1) input clocks. These clocks are the first ones of the cycle, starting with the clock in which `fp` is 1.
- R6: `fp` is high for a single input clock per output cycle.
- R7: A change of `sw_sel`, `swallow_a` or `prog_n` leaves the output cycle in progress unchanged. The new values set the length of the next output cycle.
- R8: A `prog_n` value below `N_MIN` (including 0) divides as if N were `N_MIN`.
- R9: The largest settings, N=2^`N_W`−1 and A=2^`A_W`−1, give M×N+A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_sel | input | 1 | Base modulus select: 0 picks PRE_LO, 1 picks PRE_HI |
| swallow_a | input | A_W | Swallow value A |
| prog_n | input | N_W | Main program value N |
| fp | output | 1 | Divided output pulse, one clock per cycle |
| mod_ctl | output | 1 | 1 while the prescaler divides by M+1 |

## Verification
The bench builds the block with a 4/5 and 8/9 prescaler, a 3-bit swallow value, a 4-bit program value and `N_MIN`=2. This makes every legal (select, N, A) combination short enough to sweep completely. Each setting is applied mid-cycle. The bench then measures two full intervals: the first must still match the previous setting, and the second must match the new one. The bench also counts `mod_ctl` clocks in every cycle. A final step drives N values under the floor to exercise the clamp.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  typedef enum logic {
    MOD_BASE_LO = 1'b0,
    MOD_BASE_HI = 1'b1
  } pswal_mod_e;
endpackage

// File: rtl/pswal_prescaler.sv
module pswal_prescaler #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] len_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= len_i - CW'(1);
    end else begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/pswal_seq.sv
module pswal_seq
  import pswal_pkg::*;
#(
  parameter int A_W   = 8,
  parameter int N_W   = 11,
  parameter int N_MIN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           sw_i,
  input  logic [A_W-1:0] a_i,
  input  logic [N_W-1:0] n_i,
  output logic           next_plus_o,
  output pswal_mod_e     next_sel_o,
  output pswal_mod_e     sel_o,
  output logic           mc_o,
  output logic           wrap_o
);
  localparam logic [N_W-1:0] NFLOOR = N_W'(N_MIN);

  logic [A_W-1:0] a_rem_q;
  logic [N_W-1:0] n_rem_q;
  pswal_mod_e     sel_q;
  logic           last;
  logic [A_W-1:0] a_dec;
  logic [N_W-1:0] n_eff;

  assign last   = (n_rem_q <= N_W'(1));
  assign a_dec  = a_rem_q - A_W'(a_rem_q != '0);
  assign n_eff  = (n_i < NFLOOR) ? NFLOOR : n_i;

  assign next_plus_o = last ? (a_i != '0) : (a_dec != '0);
  assign next_sel_o  = last ? pswal_mod_e'(sw_i) : sel_q;
  assign sel_o       = sel_q;
  assign mc_o        = (a_rem_q != '0);
  assign wrap_o      = tick_i && (n_rem_q == N_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rem_q <= '0;
      n_rem_q <= '0;
      sel_q   <= MOD_BASE_LO;
    end else if (tick_i) begin
      if (last) begin
        a_rem_q <= a_i;
        n_rem_q <= n_eff;
        sel_q   <= pswal_mod_e'(sw_i);
      end else begin
        a_rem_q <= a_dec;
        n_rem_q <= n_rem_q - N_W'(1);
      end
    end
  end
endmodule

// File: rtl/pswal_fb_divider.sv
module pswal_fb_divider
  import pswal_pkg::*;
#(
  parameter int PRE_LO = 128,
  parameter int PRE_HI = 256,
  parameter int A_W    = 8,
  parameter int N_W    = 11,
  parameter int N_MIN  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sw_sel,
  input  logic [A_W-1:0] swallow_a,
  input  logic [N_W-1:0] prog_n,
  output logic           fp,
  output logic           mod_ctl
);
  localparam int CW = $clog2(PRE_HI + 2);

  logic          pre_tick;
  logic          next_plus;
  pswal_mod_e    next_sel;
  pswal_mod_e    cyc_sel;
  logic          wrap;
  logic [CW-1:0] pre_len;
  logic          fp_q;

  assign pre_len = ((next_sel == MOD_BASE_HI) ? CW'(PRE_HI) : CW'(PRE_LO))
                 + CW'(next_plus);

  pswal_prescaler #(.CW(CW)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .len_i  (pre_len),
    .tick_o (pre_tick)
  );

  pswal_seq #(.A_W(A_W), .N_W(N_W), .N_MIN(N_MIN)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (pre_tick),
    .sw_i        (sw_sel),
    .a_i         (swallow_a),
    .n_i         (prog_n),
    .next_plus_o (next_plus),
    .next_sel_o  (next_sel),
    .sel_o       (cyc_sel),
    .mc_o        (mod_ctl),
    .wrap_o      (wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fp_q <= 1'b0;
    else        fp_q <= wrap;
  end

  assign fp = fp_q;
endmodule

// File: rtl/pswal_fb_divider_chk.sv
module pswal_fb_divider_chk #(
  parameter int PRE_LO = 128,
  parameter int PRE_HI = 256,
  parameter int CW     = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fp,
  input logic          mod_ctl,
  input logic          cyc_sel,
  input logic [CW-1:0] pre_len
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_q | fp;
  end

  p_fp_one_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp);

  p_mc_rise_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $rose(mod_ctl)) |-> fp);

  p_sel_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !fp) |-> $stable(cyc_sel));

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_len >= CW'(PRE_LO)) && (pre_len <= CW'(PRE_HI + 1)));

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!fp && !mod_ctl || $time == 0);
    end
  end
endmodule

bind pswal_fb_divider pswal_fb_divider_chk #(
  .PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .CW(CW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fp      (fp),
  .mod_ctl (mod_ctl),
  .cyc_sel (cyc_sel),
  .pre_len (pre_len)
);

// File: tb/pswal_fb_divider_bench.sv
module pswal_fb_divider_bench;
  localparam int CLK_P  = 10;
  localparam int PLO    = 4;
  localparam int PHI    = 8;
  localparam int AW     = 3;
  localparam int NW     = 4;
  localparam int NMIN   = 2;
  localparam int WD_MAX = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_sel = 1'b0;
  logic [AW-1:0] swallow_a = '0;
  logic [NW-1:0] prog_n = NW'(NMIN);
  logic          fp;
  logic          mod_ctl;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  always #(CLK_P/2) clk = ~clk;

  pswal_fb_divider #(.PRE_LO(PLO), .PRE_HI(PHI), .A_W(AW), .N_W(NW), .N_MIN(NMIN))
    u_pswal_fb_divider (.clk(clk), .rst_n(rst_n), .sw_sel(sw_sel),
      .swallow_a(swallow_a), .prog_n(prog_n), .fp(fp), .mod_ctl(mod_ctl));

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == WD_MAX) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", wd, WD_MAX);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int exp_ratio(int s, int a, int n);
    int ne = (n < NMIN) ? NMIN : n;
    int m  = s ? PHI : PLO;
    return m * ne + a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fp();
    do @(negedge clk); while (!fp);
  endtask

  // Called at a negedge with fp=1; returns at the next such negedge.
  task automatic measure(output int len, output int mcnt, output bit wide_ok);
    len = 0; mcnt = 0; wide_ok = 1'b1;
    do begin
      if (mod_ctl) mcnt++;
      @(negedge clk);
      len++;
      if (len == 1 && fp) wide_ok = 1'b0;
    end while (!fp);
  endtask

  task automatic run_cfg(input int s, input int a, input int n,
                         input int ps, input int pa, input int pn, input string tag);
    int len; int mc; bit w;
    sw_sel = s[0]; swallow_a = AW'(a); prog_n = NW'(n);
    measure(len, mc, w);
    check(len == exp_ratio(ps, pa, pn), "R7", len, exp_ratio(ps, pa, pn));
    measure(len, mc, w);
    check(len == exp_ratio(s, a, n), tag, len, exp_ratio(s, a, n));
    check(mc == a * ((s ? PHI : PLO) + 1), (a == 0) ? "R4" : "R5", mc, a * ((s ? PHI : PLO) + 1));
    check(w, "R6", int'(w), 1);
  endtask

  initial begin
    int ps; int pa; int pn;
    repeat (3) @(negedge clk);
    check(fp == 1'b0, "R1", int'(fp), 0);
    check(mod_ctl == 1'b0, "R1", int'(mod_ctl), 0);
    rst_n = 1'b1;
    wait_fp();
    ps = 0; pa = 0; pn = NMIN;
    for (int s = 0; s < 2; s++) begin
      for (int n = NMIN; n < (1 << NW); n++) begin
        for (int a = 0; a < n && a < (1 << AW); a++) begin
          string tag;
          if (n == (1 << NW) - 1 && a == (1 << AW) - 1) tag = "R9";
          else if (a == 0) tag = "R4";
          else tag = s ? "R3" : "R2";
          run_cfg(s, a, n, ps, pa, pn, tag);
          ps = s; pa = a; pn = n;
        end
      end
    end
    // R8: program values under the floor
    run_cfg(0, 1, 0, ps, pa, pn, "R8");
    run_cfg(1, 1, 1, 0, 1, 0, "R8");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule